// File: doc/BRIEF.md
# Serial Peripheral Slave with Busy Handshake

This block is the receiving end of a four-wire serial link in which an external master owns the serial clock. While the active-low select line is held low, the block takes one data bit from the master on every qualifying clock edge and returns one bit of its own on the return line at the same pace. Run-time inputs choose whether bytes travel most-significant or least-significant bit first, and whether the rising or the falling serial clock edge is the one that counts. All serial lines are sampled by the fast system clock through short synchronisers. The system clock must run at least four times faster than the serial clock, and each serial clock phase must last at least three system clock periods.

On the system side, received bytes leave through a valid/ready stream and outgoing bytes enter through a second valid/ready stream that feeds a one-byte holding register. The busy output stays high from the moment a byte completes until the system side accepts it, so that the master can pause between bytes. Releasing select drops any partly shifted byte and rewinds the bit count. The next selection therefore always starts on a byte boundary.

Back-pressure rules: a received byte stays on `rx_data_o` with `rx_valid_o` high until `rx_ready_i` is seen high at a clock edge. A byte that completes while an earlier byte is still held is lost. `tx_ready_o` is high only when the holding register is empty. A byte is accepted on any edge where `tx_valid_i` and `tx_ready_o` are both high.

Top module: `spi_busy_slave`

## Requirements
- R1: Serial clock edges that arrive while select is high are ignored. They complete no byte and move no data.
- R2: A rising edge on select discards any partial byte and clears the bit count, so the next selection receives a fresh full byte.
- R3: The data line is sampled on the rising serial clock edge when `cfg_sample_fall` is 0, and on the falling edge when it is 1.
- R4: With `cfg_lsb_first` = 0, the first bit received lands in bit 7 of the byte. With `cfg_lsb_first` = 1, it lands in bit 0.
- R5: The return line shows the first bit of the outgoing byte once select goes low, and the next bit after each sampling edge. It uses the same bit order as R4.
- R6: `tx_ready_o` is high only while the holding register is empty. The holding register is emptied into the shifter when select falls and whenever a byte completes. If the register is empty at that moment, the byte sent is 0xFF.
- R7: `rx_valid_o` rises after the eighth sampling edge of a byte. The value on `rx_data_o` then stays stable until it is accepted. A byte that completes while an earlier byte is still held is discarded.
- R8: With `cfg_busy_en` = 1, `busy_o` is high exactly while a received byte waits for acceptance. With `cfg_busy_en` = 0, `busy_o` stays low.
- R9: While select is high, `miso_oe_o` is low and `miso_o` is driven low.
- R10: After reset, `rx_valid_o`, `busy_o` and `miso_oe_o` are low and `tx_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lsb_first | input | 1 | 1 = least-significant bit first, 0 = most-significant first |
| cfg_sample_fall | input | 1 | 1 = sample on falling serial clock edge, 0 = rising |
| cfg_busy_en | input | 1 | Enables the busy output |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the return line pad |
| busy_o | output | 1 | High while a received byte awaits acceptance |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | System side accepts the received byte |
| rx_data_o | output | DATA_W | Received byte |
| tx_valid_i | input | 1 | Outgoing byte offered |
| tx_ready_o | output | 1 | Holding register empty |
| tx_data_i | input | DATA_W | Outgoing byte |

## Verification
A bit counter that drifts, or one that is not cleared when select is released, shows up at the ports on the very next byte. That byte is either rotated or assembled from bits of two transfers, and `rx_valid_o` rises on the wrong serial clock edge, within four system clocks of that edge. A shifter that reloads at the wrong moment gives the master a wrong return bit at its next sample point. A stale holding flag shows as `tx_ready_o` failing to return high after select falls. A reference model that tracks the synchroniser delay compares every output on every system clock, so a divergence is reported in the cycle where it first appears.

// File: rtl/spi_busy_pkg.sv
package spi_busy_pkg;

  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } sample_edge_e;

endpackage

// File: rtl/spi_sync_level.sv
// Multi-stage synchroniser that also keeps one extra delayed copy of the line,
// so the parent module can detect edges.
module spi_sync_level #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic prev_o
);

  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES + 1){RST_VAL}};
    else        pipe <= {pipe[STAGES-1:0], d_i};
  end

  assign level_o = pipe[STAGES-1];
  assign prev_o  = pipe[STAGES];

endmodule

// File: rtl/spi_tx_hold.sv
// One-byte holding register that sits between the transmit stream and the shifter.
module spi_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      if (take_i) full_o <= 1'b0;
      if (tx_valid_i && !full_o) begin
        data_o <= tx_data_i;
        full_o <= 1'b1;
      end
    end
  end

  assign tx_ready_o = !full_o;

  // R6
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

endmodule

// File: rtl/spi_rx_port.sv
// Receive stream and busy flag.
module spi_rx_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              busy_en_i,
  input  logic              rx_ready_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      if (rx_valid_o && rx_ready_i) rx_valid_o <= 1'b0;
      if (done_i && !rx_valid_o) begin
        rx_valid_o <= 1'b1;
        rx_data_o  <= byte_i;
      end
    end
  end

  assign busy_o = busy_en_i && rx_valid_o;

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && rx_ready_i) |=> !busy_o);

endmodule

// File: rtl/spi_shift_core.sv
// Bit counter together with the receive and transmit shift registers.
module spi_shift_core
  import spi_busy_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              act_i,
  input  logic              ss_rise_i,
  input  logic              ss_fall_i,
  input  logic              mosi_i,
  input  bit_order_e        order_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              done_o,
  output logic              take_o,
  output logic              miso_o,
  output logic [DATA_W-1:0] rx_byte_o
);

  localparam int              CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh, rx_next, tx_next, load_val;
  logic              last_bit;

  always_comb begin
    if (order_i == ORDER_LSB) begin
      rx_next = {mosi_i, rx_sh[DATA_W-1:1]};
      tx_next = {1'b1, tx_sh[DATA_W-1:1]};
      miso_o  = tx_sh[0];
    end else begin
      rx_next = {rx_sh[DATA_W-2:0], mosi_i};
      tx_next = {tx_sh[DATA_W-2:0], 1'b1};
      miso_o  = tx_sh[DATA_W-1];
    end
  end

  assign load_val  = hold_full_i ? hold_data_i : {DATA_W{1'b1}};
  assign last_bit  = (cnt == LAST);
  assign done_o    = act_i && last_bit && !ss_rise_i && !ss_fall_i;
  assign take_o    = ss_fall_i || done_o;
  assign rx_byte_o = rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= '1;
    end else if (ss_rise_i) begin
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= '1;
    end else if (ss_fall_i) begin
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= load_val;
    end else if (act_i) begin
      rx_sh <= rx_next;
      if (last_bit) begin
        cnt   <= '0;
        tx_sh <= load_val;
      end else begin
        cnt   <= cnt + 1'b1;
        tx_sh <= tx_next;
      end
    end
  end

  // R1
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (cnt == '0));

  // R2
  rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_rise_i |=> (cnt == '0 && rx_sh == '0));

endmodule

// File: rtl/spi_busy_slave.sv
module spi_busy_slave
  import spi_busy_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lsb_first,
  input  logic              cfg_sample_fall,
  input  logic              cfg_busy_en,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              busy_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i
);

  logic ss_lvl, ss_prv, sck_lvl, sck_prv;
  logic [SYNC_STAGES-1:0] mosi_pipe;
  logic sel, ss_rise, ss_fall, act;
  logic done, take, core_miso, hold_full;
  logic [DATA_W-1:0] hold_data, rx_byte;
  sample_edge_e edge_sel;
  bit_order_e   order;

  spi_sync_level #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ss_n_i), .level_o(ss_lvl), .prev_o(ss_prv)
  );

  spi_sync_level #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sck_i), .level_o(sck_lvl), .prev_o(sck_prv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mosi_pipe <= '0;
    else        mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_i};
  end

  assign edge_sel = sample_edge_e'(cfg_sample_fall);
  assign order    = bit_order_e'(cfg_lsb_first);
  assign sel      = !ss_lvl;
  assign ss_rise  = ss_lvl && !ss_prv;
  assign ss_fall  = !ss_lvl && ss_prv;
  assign act      = sel && ((edge_sel == EDGE_FALL) ? (sck_prv && !sck_lvl)
                                                    : (!sck_prv && sck_lvl));

  spi_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
    .tx_ready_o(tx_ready_o), .take_i(take), .full_o(hold_full), .data_o(hold_data)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .act_i(act), .ss_rise_i(ss_rise),
    .ss_fall_i(ss_fall), .mosi_i(mosi_pipe[SYNC_STAGES-1]), .order_i(order),
    .hold_full_i(hold_full), .hold_data_i(hold_data), .done_o(done),
    .take_o(take), .miso_o(core_miso), .rx_byte_o(rx_byte)
  );

  spi_rx_port #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .done_i(done), .byte_i(rx_byte),
    .busy_en_i(cfg_busy_en), .rx_ready_i(rx_ready_i), .rx_valid_o(rx_valid_o),
    .rx_data_o(rx_data_o), .busy_o(busy_o)
  );

  assign miso_oe_o = sel;
  assign miso_o    = sel && core_miso;

  // R9
  oe_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_lvl) |-> !miso_oe_o);

endmodule

// File: tb/tb_spi_busy_slave.sv
module tb_spi_busy_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lsb_first = 1'b0, cfg_sample_fall = 1'b0, cfg_busy_en = 1'b1;
  logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic rx_ready = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic miso, miso_oe, busy, rx_valid, tx_ready;
  logic [7:0] rx_data;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_busy_slave dut (
    .clk(clk), .rst_n(rst_n), .cfg_lsb_first(cfg_lsb_first),
    .cfg_sample_fall(cfg_sample_fall), .cfg_busy_en(cfg_busy_en),
    .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi), .miso_o(miso),
    .miso_oe_o(miso_oe), .busy_o(busy), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .rx_data_o(rx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .tx_data_i(tx_data)
  );

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: the lines are seen two clocks late, then one more clock
  // of history is used to find edges.
  logic hs[4], hk[4], hm[4];
  int   m_cnt;
  logic [7:0] m_rx, m_tx, m_hold, m_rxd;
  logic m_hf, m_rxv;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hs[i] = 1'b1; hk[i] = 1'b0; hm[i] = 1'b0; end
      m_cnt = 0; m_rx = 0; m_tx = 8'hFF; m_hold = 0; m_rxd = 0; m_hf = 0; m_rxv = 0;
    end else begin
      logic rise, fall, act, done, take, nv, nf;
      logic [7:0] got;
      for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hk[i] = hk[i-1]; hm[i] = hm[i-1]; end
      hs[0] = ss_n; hk[0] = sck; hm[0] = mosi;
      rise = hs[2] && !hs[3];
      fall = !hs[2] && hs[3];
      act  = !hs[2] && (cfg_sample_fall ? (hk[3] && !hk[2]) : (!hk[3] && hk[2]));
      done = 0; take = 0; got = 0;
      if (rise) begin
        m_cnt = 0; m_rx = 0; m_tx = 8'hFF;
      end else if (fall) begin
        m_cnt = 0; m_rx = 0; m_tx = m_hf ? m_hold : 8'hFF; take = 1;
      end else if (act) begin
        m_rx = cfg_lsb_first ? {hm[2], m_rx[7:1]} : {m_rx[6:0], hm[2]};
        if (m_cnt == 7) begin
          done = 1; got = m_rx; m_cnt = 0; take = 1;
          m_tx = m_hf ? m_hold : 8'hFF;
        end else begin
          m_cnt++;
          m_tx = cfg_lsb_first ? {1'b1, m_tx[7:1]} : {m_tx[6:0], 1'b1};
        end
      end
      nv = m_rxv;
      if (m_rxv && rx_ready) nv = 0;
      if (done && !m_rxv) begin nv = 1; m_rxd = got; end
      m_rxv = nv;
      nf = m_hf;
      if (take) nf = 0;
      if (tx_valid && !m_hf) begin m_hold = tx_data; nf = 1; end
      m_hf = nf;
    end
  end

  // Every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R7", "rx_valid", rx_valid, m_rxv);
      if (m_rxv) check("R4", "rx_data", rx_data, m_rxd);
      check("R6", "tx_ready", tx_ready, !m_hf);
      check("R8", "busy", busy, cfg_busy_en && m_rxv);
      check("R9", "miso_oe", miso_oe, !hs[1]);
      if (!hs[1]) check("R5", "miso", miso, cfg_lsb_first ? m_tx[0] : m_tx[7]);
      else        check("R9", "miso_idle", miso, 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(logic [7:0] d);
    tx_valid = 1; tx_data = d;
    cyc(1);
    tx_valid = 0;
  endtask

  task automatic ack();
    rx_ready = 1; cyc(1); rx_ready = 0; cyc(1);
  endtask

  task automatic select();   ss_n = 0; cyc(8); endtask
  task automatic deselect(); ss_n = 1; cyc(8); endtask

  task automatic xfer(int nbits, logic [7:0] out_b, output logic [7:0] in_b);
    in_b = 0;
    for (int i = 0; i < nbits; i++) begin
      int idx = cfg_lsb_first ? i : 7 - i;
      cyc(3); mosi = out_b[idx]; cyc(3);
      if (!cfg_sample_fall) in_b[idx] = miso;
      sck = 1; cyc(6);
      if (cfg_sample_fall) in_b[idx] = miso;
      sck = 0;
    end
    cyc(6);
  endtask

  logic [7:0] got;

  initial begin
    cyc(3);
    // R10
    check("R10", "rx_valid reset", rx_valid, 0);
    check("R10", "tx_ready reset", tx_ready, 1);
    check("R10", "busy reset", busy, 0);
    check("R10", "miso_oe reset", miso_oe, 0);
    rst_n = 1; cyc(4);

    // MSB first, rising edge sampling
    load_tx(8'hA5);
    check("R6", "tx_ready after load", tx_ready, 0);
    select();
    check("R6", "tx_ready after select", tx_ready, 1);
    xfer(8, 8'h3C, got);
    check("R5", "miso byte msb", got, 8'hA5);
    check("R3", "rx_valid rising", rx_valid, 1);
    check("R4", "rx byte msb", rx_data, 8'h3C);
    check("R8", "busy pending", busy, 1);
    ack();
    check("R8", "busy after ack", busy, 0);
    xfer(8, 8'hC3, got);
    check("R6", "empty hold sends FF", got, 8'hFF);
    check("R4", "second rx byte", rx_data, 8'hC3);
    ack();
    deselect();

    // LSB first, falling edge sampling
    cfg_lsb_first = 1; cfg_sample_fall = 1; cyc(4);
    load_tx(8'h47);
    select();
    xfer(8, 8'h1E, got);
    check("R5", "miso byte lsb", got, 8'h47);
    check("R3", "rx_valid falling", rx_valid, 1);
    check("R4", "rx byte lsb", rx_data, 8'h1E);
    ack();
    deselect();

    // Partial byte dropped on deselect
    cfg_lsb_first = 0; cfg_sample_fall = 0; cyc(4);
    select();
    xfer(3, 8'hE0, got);
    deselect();
    check("R2", "no rx after partial", rx_valid, 0);
    select();
    xfer(8, 8'h5A, got);
    check("R2", "fresh byte after partial", rx_data, 8'h5A);
    check("R2", "valid after fresh byte", rx_valid, 1);
    ack();
    deselect();

    // Clock activity while deselected
    for (int i = 0; i < 10; i++) begin sck = 1; mosi = ~mosi; cyc(4); sck = 0; cyc(4); end
    check("R1", "no rx while deselected", rx_valid, 0);
    check("R9", "oe low while deselected", miso_oe, 0);
    mosi = 0;
    select();
    xfer(8, 8'h96, got);
    check("R1", "byte boundary kept", rx_data, 8'h96);
    ack();
    deselect();

    // Overrun: second byte lost while first is held
    select();
    xfer(8, 8'h11, got);
    xfer(8, 8'h22, got);
    check("R7", "held byte kept", rx_data, 8'h11);
    check("R8", "busy held during overrun", busy, 1);
    ack();
    check("R7", "lost byte not presented", rx_valid, 0);
    deselect();

    // Busy disabled
    cfg_busy_en = 0; cyc(4);
    select();
    xfer(8, 8'h7E, got);
    check("R8", "busy disabled", busy, 0);
    check("R7", "valid with busy off", rx_valid, 1);
    ack();
    deselect();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule